// File: doc/BRIEF.md
# Recirculating Shift-Register Sample Buffer

This block is a fixed-length delay line of sample registers that keeps a window of recent input samples for a FIR filter datapath. In loading mode each enabled clock edge pushes one external sample into the head stage. Every stored sample moves one stage closer to the tail, and the oldest sample is shown at the output.

Raising the source-select line closes a feedback loop from the tail register back to the head. The stored window then rotates, so the filter can walk past every stored sample one per enabled cycle without losing any of them. Dropping the shift enable freezes all stages for as long as needed.

The output comes straight from the tail register. There is no combinational path from any input to the output. The depth and sample width are parameters, and their defaults are 21 stages of 10 bits.

Top module: `ring_delay_line`

## Requirements
- R1: A synchronous active-high reset clears every stage to zero, so the output reads 0 after reset, and a full rotation after reset also yields only zeros.
- R2: The line has DEPTH stages (default 21), each WIDTH bits wide (default 10), and a full-scale value 10'h3FF is stored without loss.
- R3: When `recirc` is 0 and `shift_en` is 1 on a rising edge, the head stage loads `smp_in`.
- R4: When `recirc` is 1 and `shift_en` is 1 on a rising edge, the head stage loads the current value of `smp_out`.
- R5: On each rising edge with `shift_en` at 1, every stage k>0 takes the previous value of stage k-1.
- R6: On a rising edge with `shift_en` at 0, all stages keep their values, and `smp_out` stays constant whatever `smp_in` and `recirc` do.
- R7: A sample loaded on an enabled edge reaches `smp_out` right after the 21st enabled edge counted from that edge, with the loading edge itself counted as the first.
- R8: During recirculation, `shift_en` may be low for any number of cycles between enabled edges, and the rotated sequence at the output is the same as a gap-free rotation.
- R9: Reset takes priority over `shift_en` and `recirc`, so an edge with both reset and enable high clears all stages.
- R10: `smp_out` changes only at a rising clock edge; a change of `smp_in` between edges has no effect on it.
- R11: In circular mode with `shift_en` held high, the output sequence repeats with a period of exactly DEPTH enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | WIDTH | External sample input |
| recirc | input | 1 | Head source select: 0 external, 1 tail output |
| shift_en | input | 1 | Advance all stages by one position |
| smp_out | output | WIDTH | Registered tail-stage value |

## Verification
In circular mode, the tail value is written into the head on the same edge that replaces the tail with the value of the stage before it. The bench provokes this with long runs of enabled rotation, and it judges each cycle's output against an independent queue model and against the value seen one period earlier. Reset and enable also meet on one edge: the bench asserts reset together with shift enable while a nonzero sample is being loaded, and it expects zeros at the output and through the following rotation.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  localparam int unsigned RDL_DEPTH = 21;
  localparam int unsigned RDL_WIDTH = 10;

  typedef enum logic {
    SRC_EXT  = 1'b0,
    SRC_RING = 1'b1
  } rdl_src_e;
endpackage

// File: rtl/rdl_stage.sv
module rdl_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rdl_feed_mux.sv
module rdl_feed_mux
  import rdl_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  rdl_src_e     src,
  input  logic [W-1:0] ext_d,
  input  logic [W-1:0] ring_d,
  output logic [W-1:0] head_d
);
  always_comb begin
    unique case (src)
      SRC_RING: head_d = ring_d;
      default:  head_d = ext_d;
    endcase
  end
endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line
  import rdl_pkg::*;
#(
  parameter int unsigned DEPTH = RDL_DEPTH,
  parameter int unsigned WIDTH = RDL_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] smp_in,
  input  logic             recirc,
  input  logic             shift_en,
  output logic [WIDTH-1:0] smp_out
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]            feed_d;
  logic [WIDTH-1:0]            head_q;
  rdl_src_e                    src_sel;

  assign src_sel = rdl_src_e'(recirc);

  rdl_feed_mux #(.W(WIDTH)) u_feed (
    .src    (src_sel),
    .ext_d  (smp_in),
    .ring_d (stage_q[LAST]),
    .head_d (feed_d)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      rdl_stage #(.W(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .d   (feed_d),
        .q   (stage_q[i])
      );
    end else begin : g_body
      rdl_stage #(.W(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .d   (stage_q[i-1]),
        .q   (stage_q[i])
      );
    end
  end

  assign head_q  = stage_q[0];
  assign smp_out = stage_q[LAST];
endmodule

// File: rtl/rdl_checker.sv
module rdl_checker #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         recirc,
  input logic         shift_en,
  input logic [W-1:0] smp_in,
  input logic [W-1:0] smp_out,
  input logic [W-1:0] first_q
);
  // R1 / R9: reset clears the line even when enable is high
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (smp_out == '0 && first_q == '0));

  // R6: no enable means nothing moves
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(smp_out));

  assert_hold_head_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(first_q));

  // R3: external feed into head
  assert_ext_feed_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !recirc) |=> first_q == $past(smp_in));

  // R4: ring feed from tail into head
  assert_ring_feed_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && recirc) |=> first_q == $past(smp_out));
endmodule

bind ring_delay_line rdl_checker #(.W(WIDTH)) u_rdl_chk (
  .clk      (clk),
  .rst      (rst),
  .recirc   (recirc),
  .shift_en (shift_en),
  .smp_in   (smp_in),
  .smp_out  (smp_out),
  .first_q  (head_q)
);

// File: tb/ring_delay_line_test.sv
module ring_delay_line_test;
  localparam int unsigned D = 21;
  localparam int unsigned W = 10;
  localparam time CLK_P = 8ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] smp_in = '0;
  logic         recirc = 1'b0;
  logic         shift_en = 1'b0;
  logic [W-1:0] smp_out;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  logic [W-1:0] model [D];
  logic [W-1:0] hist [64];

  always #(CLK_P/2) clk = ~clk;

  ring_delay_line #(.DEPTH(D), .WIDTH(W)) uut (
    .clk(clk), .rst(rst), .smp_in(smp_in), .recirc(recirc),
    .shift_en(shift_en), .smp_out(smp_out)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic cyc(input logic r, input logic en, input logic sel,
                     input logic [W-1:0] din, input string tag);
    rst = r; shift_en = en; recirc = sel; smp_in = din;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < D; k++) model[k] = '0;
    end else if (en) begin
      logic [W-1:0] nh;
      nh = sel ? model[D-1] : din;
      for (int k = D-1; k > 0; k--) model[k] = model[k-1];
      model[0] = nh;
    end
    @(negedge clk);
    check(smp_out, model[D-1], tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] first;
    for (int k = 0; k < D; k++) model[k] = '0;
    @(negedge clk);
    // R1 reset state
    cyc(1'b1, 1'b0, 1'b0, '0, "R1");
    cyc(1'b1, 1'b0, 1'b0, '0, "R1");
    // R1 all stages zero: rotate a full period
    for (int i = 0; i < D; i++) cyc(1'b0, 1'b1, 1'b1, 10'h155, "R1");

    // R3 / R7 fill from external input
    for (int i = 0; i < D; i++)
      cyc(1'b0, 1'b1, 1'b0, W'((i * 37 + 5) % 1024), "R3");
    first = W'(5);
    check(smp_out, first, "R7");

    // R4 / R11 rotation for two periods, record and compare
    for (int i = 0; i < 2*D; i++) begin
      cyc(1'b0, 1'b1, 1'b1, 10'h2AA, "R4");
      hist[i] = smp_out;
    end
    for (int i = 0; i < D; i++) check(hist[i+D], hist[i], "R11");
    for (int i = 0; i < D; i++) check(hist[i], W'((((i+1) % D) * 37 + 5) % 1024), "R5");

    // R8 recirculation with enable gaps of varying length
    for (int i = 0; i < 60; i++)
      cyc(1'b0, (i % 4) == 0 || (i % 7) == 3, 1'b1, W'(i), "R8");

    // R6 hold: toggle inputs with enable low
    first = smp_out;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 1'b0, i[0], W'(i * 91), "R6");
      check(smp_out, first, "R6");
    end

    // R10: change input between edges, output unchanged
    shift_en = 1'b0;
    smp_in = 10'h3C3;
    #1;
    check(smp_out, first, "R10");
    smp_in = 10'h03C;
    #1;
    check(smp_out, first, "R10");

    // R2 full-scale value survives a full rotation
    cyc(1'b0, 1'b1, 1'b0, 10'h3FF, "R2");
    for (int i = 0; i < D-1; i++) cyc(1'b0, 1'b1, 1'b1, '0, "R2");
    check(smp_out, 10'h3FF, "R2");

    // R9 reset together with enable and nonzero load
    cyc(1'b1, 1'b1, 1'b0, 10'h1E1, "R9");
    check(smp_out, '0, "R9");
    for (int i = 0; i < D; i++) cyc(1'b0, 1'b1, 1'b1, 10'h0F0, "R9");

    // R5 partial load then mixed modes
    for (int i = 0; i < 30; i++)
      cyc(1'b0, (i % 5) != 2, (i > 12), W'(i * 13 + 1), "R5");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule